// File: doc/BRIEF.md
# Earliest-Deadline-First Cell Scheduler

This block orders fixed-size cells from a set of virtual circuits (VCs) for one output link. Each VC has a programmable deadline value. When a cell arrives, the block adds that VC's deadline to a free-running cell-slot clock. The sum is the cell's due time, and it is stored with the cell in one of a fixed number of storage slots. Whenever the link can take a cell, the block offers the stored cell with the earliest due time. Cells with the same due time leave in order of increasing VC number.

The output is a valid/ready port. Once a cell is offered, it stays on the port unchanged until the link accepts it, so a cell that has started to leave is never displaced by a more urgent newcomer. Arrivals have no back-pressure. An arrival that finds every slot taken is discarded, and a sticky flag records the loss. The slot clock wraps around, and due times are compared by modular difference, so a rollover does not reorder cells. Deadline values may be rewritten at any time. A new value applies only to cells that arrive after the write.

Top module: `edf_cell_sched`

## Requirements
- R1: During and after a synchronous active-low reset, `deq_valid` and `overflow` are 0, every slot is empty, every deadline value is 0 and the slot clock is 0.
- R2: The slot clock starts at 0 on the first clock edge after reset is released and advances by one every cycle. A cell accepted at an edge gets the due time (clock value at that edge + its VC's deadline) modulo 2^TIME_W, and `deq_due` presents that value.
- R3: An arrival at an edge where all SLOTS slots are occupied is discarded. `overflow` goes to 1 after that edge and stays 1 until reset. Storage is not changed.
- R4: The offered cell is the stored cell with the earliest due time among the cells that are not being accepted.
- R5: When stored cells share the earliest due time, the one with the lowest VC number is offered first.
- R6: While `deq_valid` is 1 and `deq_ready` is 0, `deq_vc`, `deq_tag` and `deq_due` hold their values, even if a more urgent cell arrives.
- R7: Due times are ordered by the sign bit of their TIME_W-bit difference. Across a clock rollover, a due time just below 2^TIME_W is earlier than a small, wrapped one.
- R8: A deadline write to a VC in the same cycle as an arrival on that VC does not affect that arrival. It affects arrivals from the next cycle on.
- R9: A cell accepted at edge k can be offered from edge k+1, so it is visible after the second edge. A slot is freed at the edge where its handshake completes, and an arrival at that same edge cannot use it.
- R10: When `deq_valid` is 1, `deq_vc`, `deq_tag` and `deq_due` belong to one stored cell. That cell leaves storage when `deq_valid` and `deq_ready` are both 1 at an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arr_valid | input | 1 | A cell arrives this cycle |
| arr_vc | input | VC_W | VC number of the arriving cell |
| arr_tag | input | TAG_W | Tag carried with the arriving cell |
| cfg_we | input | 1 | Write a deadline value |
| cfg_vc | input | VC_W | VC whose deadline is written |
| cfg_deadline | input | DL_W | New deadline in cell slots |
| deq_ready | input | 1 | Output link can take a cell |
| deq_valid | output | 1 | A cell is offered |
| deq_vc | output | VC_W | VC number of the offered cell |
| deq_tag | output | TAG_W | Tag of the offered cell |
| deq_due | output | TIME_W | Due time of the offered cell |
| overflow | output | 1 | Sticky: an arrival was discarded |

## Verification
The bench targets the clock rollover. There, a design that compares due times as plain unsigned numbers would send a wrapped, later cell ahead of an earlier one. It sets up equal due times from different VCs, which catches a tie-break by slot or by arrival order. It also holds a cell on the port while a more urgent cell arrives, which exposes any design that swaps the offered cell before acceptance. Finally, it fills every slot and then adds one arrival at the same edge as a handshake. A design that reuses the departing slot at once, or does not record the drop, fails here, and so does a design that writes a deadline change into the arrival made in the same cycle.

// File: rtl/edf_sched_pkg.sv
`timescale 1ns/1ps
// edf_sched_pkg: shared ordering rule for the scheduler.
// Assumes due times being compared lie within half the clock range of each other.
package edf_sched_pkg;

    // Returns 1 when candidate a should leave before candidate b.
    function automatic logic first_wins(
        input logic        a_v,
        input logic [31:0] a_due,
        input logic [31:0] a_vc,
        input logic        b_v,
        input logic [31:0] b_due,
        input logic [31:0] b_vc,
        input int unsigned tw
    );
        logic [31:0] diff;
        diff = a_due - b_due;
        if (!b_v)           return 1'b1;
        if (!a_v)           return 1'b0;
        if (a_due == b_due) return (a_vc <= b_vc);
        return diff[tw-1];
    endfunction

endpackage

// File: rtl/edf_deadline_table.sv
`timescale 1ns/1ps
// edf_deadline_table: one deadline register per VC, readable by the arrival path.
// Assumes a write lands at the clock edge, so a same-cycle read sees the old value.
module edf_deadline_table #(
    parameter int NUM_VC = 8,
    parameter int VC_W   = 3,
    parameter int DL_W   = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [VC_W-1:0] wr_vc,
    input  logic [DL_W-1:0] wr_dl,
    input  logic [VC_W-1:0] rd_vc,
    output logic [DL_W-1:0] rd_dl
);

    logic [NUM_VC-1:0][DL_W-1:0] dl_q;

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        // Holds the deadline of VC v and updates it on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                dl_q[v] <= '0;
            else if (wr_en && (wr_vc == VC_W'(v)))
                dl_q[v] <= wr_dl;
        end
    end

    // Reads out the deadline of the arriving VC.
    always_comb rd_dl = dl_q[rd_vc];

endmodule

// File: rtl/edf_slot_pool.sv
`timescale 1ns/1ps
// edf_slot_pool: fixed set of cell slots with occupancy, lowest-free insertion
// and a sticky drop flag. Assumes the released slot is occupied and is not
// reused at the same edge.
module edf_slot_pool #(
    parameter int SLOTS  = 8,
    parameter int SLOT_W = 3,
    parameter int VC_W   = 3,
    parameter int TAG_W  = 16,
    parameter int TIME_W = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ins_en,
    input  logic [VC_W-1:0]               ins_vc,
    input  logic [TAG_W-1:0]              ins_tag,
    input  logic [TIME_W-1:0]             ins_due,
    input  logic                          rel_en,
    input  logic [SLOT_W-1:0]             rel_slot,
    output logic [SLOTS-1:0]              occ,
    output logic [SLOTS-1:0][VC_W-1:0]    vc_q,
    output logic [SLOTS-1:0][TAG_W-1:0]   tag_q,
    output logic [SLOTS-1:0][TIME_W-1:0]  due_q,
    output logic                          full,
    output logic                          overflow
);

    logic [SLOT_W-1:0] free_idx;
    logic              do_ins;

    // Finds the lowest-numbered empty slot.
    always_comb begin
        free_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--)
            if (!occ[i]) free_idx = SLOT_W'(i);
    end

    assign full   = &occ;
    assign do_ins = ins_en && !full;

    // Tracks which slots hold a cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
        end else begin
            if (rel_en) occ[rel_slot] <= 1'b0;
            if (do_ins) occ[free_idx] <= 1'b1;
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // Captures the arriving cell into slot s when it is the chosen free slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vc_q[s]  <= '0;
                tag_q[s] <= '0;
                due_q[s] <= '0;
            end else if (do_ins && (free_idx == SLOT_W'(s))) begin
                vc_q[s]  <= ins_vc;
                tag_q[s] <= ins_tag;
                due_q[s] <= ins_due;
            end
        end
    end

    // Records that an arrival was discarded; cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overflow <= 1'b0;
        else if (ins_en && full)
            overflow <= 1'b1;
    end

endmodule

// File: rtl/edf_min_tree.sv
`timescale 1ns/1ps
// edf_min_tree: balanced comparison tree that picks the most urgent valid slot.
// Assumes SLOTS >= 2. Ties on due time go to the lower VC, then to the lower slot.
module edf_min_tree #(
    parameter int SLOTS  = 8,
    parameter int SLOT_W = 3,
    parameter int VC_W   = 3,
    parameter int TIME_W = 12
) (
    input  logic [SLOTS-1:0]             cand_v,
    input  logic [SLOTS-1:0][VC_W-1:0]   cand_vc,
    input  logic [SLOTS-1:0][TIME_W-1:0] cand_due,
    output logic                         win_v,
    output logic [SLOT_W-1:0]            win_slot
);

    localparam int LEAVES = 1 << SLOT_W;

    for (genvar l = 0; l <= SLOT_W; l++) begin : lvl
        localparam int N = LEAVES >> l;
        logic [N-1:0]             v;
        logic [N-1:0][VC_W-1:0]   vc;
        logic [N-1:0][TIME_W-1:0] due;
        logic [N-1:0][SLOT_W-1:0] sl;

        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < N; i++) begin : g_in
                if (i < SLOTS) begin : g_real
                    // Feeds a real slot into the tree.
                    assign v[i]   = cand_v[i];
                    assign vc[i]  = cand_vc[i];
                    assign due[i] = cand_due[i];
                end else begin : g_pad
                    // Pads the tree with an empty leaf.
                    assign v[i]   = 1'b0;
                    assign vc[i]  = '0;
                    assign due[i] = '0;
                end
                assign sl[i] = SLOT_W'(i);
            end
        end else begin : g_node
            for (genvar i = 0; i < N; i++) begin : g_cmp
                logic a_first;
                // Compares the two children and forwards the more urgent one.
                assign a_first = edf_sched_pkg::first_wins(
                    lvl[l-1].v[2*i],   32'(lvl[l-1].due[2*i]),   32'(lvl[l-1].vc[2*i]),
                    lvl[l-1].v[2*i+1], 32'(lvl[l-1].due[2*i+1]), 32'(lvl[l-1].vc[2*i+1]),
                    TIME_W);
                assign v[i]   = a_first ? lvl[l-1].v[2*i]   : lvl[l-1].v[2*i+1];
                assign vc[i]  = a_first ? lvl[l-1].vc[2*i]  : lvl[l-1].vc[2*i+1];
                assign due[i] = a_first ? lvl[l-1].due[2*i] : lvl[l-1].due[2*i+1];
                assign sl[i]  = a_first ? lvl[l-1].sl[2*i]  : lvl[l-1].sl[2*i+1];
            end
        end
    end

    assign win_v    = lvl[SLOT_W].v[0];
    assign win_slot = lvl[SLOT_W].sl[0];

endmodule

// File: rtl/edf_cell_sched.sv
`timescale 1ns/1ps
// edf_cell_sched: earliest-deadline-first cell scheduler.
// Stamps each arrival with clock + per-VC deadline, stores it in a slot and
// offers the most urgent stored cell on a valid/ready port that holds until taken.
// Assumes outstanding due times stay within half of 2^TIME_W of each other.
module edf_cell_sched #(
    parameter int NUM_VC = 8,
    parameter int SLOTS  = 8,
    parameter int TAG_W  = 16,
    parameter int TIME_W = 12,
    parameter int DL_W   = 10,
    parameter int VC_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arr_valid,
    input  logic [VC_W-1:0]   arr_vc,
    input  logic [TAG_W-1:0]  arr_tag,
    input  logic              cfg_we,
    input  logic [VC_W-1:0]   cfg_vc,
    input  logic [DL_W-1:0]   cfg_deadline,
    input  logic              deq_ready,
    output logic              deq_valid,
    output logic [VC_W-1:0]   deq_vc,
    output logic [TAG_W-1:0]  deq_tag,
    output logic [TIME_W-1:0] deq_due,
    output logic              overflow
);

    localparam int SLOT_W = $clog2(SLOTS);

    logic [TIME_W-1:0]             now_q;
    logic [DL_W-1:0]               arr_dl;
    logic [TIME_W-1:0]             arr_due;
    logic [SLOTS-1:0]              occ;
    logic [SLOTS-1:0][VC_W-1:0]    vc_q;
    logic [SLOTS-1:0][TAG_W-1:0]   tag_q;
    logic [SLOTS-1:0][TIME_W-1:0]  due_q;
    logic                          pool_full;
    logic [SLOTS-1:0]              rel_mask;
    logic [SLOTS-1:0]              cand_v;
    logic                          win_v;
    logic [SLOT_W-1:0]             win_slot;
    logic                          head_v;
    logic [SLOT_W-1:0]             head_slot;
    logic [VC_W-1:0]               head_vc;
    logic [TAG_W-1:0]              head_tag;
    logic [TIME_W-1:0]             head_due;
    logic                          hs;

    // Advances the cell-slot clock once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_q + 1'b1;
    end

    edf_deadline_table #(.NUM_VC(NUM_VC), .VC_W(VC_W), .DL_W(DL_W)) u_dl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_we),
        .wr_vc (cfg_vc),
        .wr_dl (cfg_deadline),
        .rd_vc (arr_vc),
        .rd_dl (arr_dl)
    );

    // Forms the due time of the arriving cell with a single addition.
    assign arr_due = now_q + TIME_W'(arr_dl);

    assign hs = head_v && deq_ready;

    edf_slot_pool #(
        .SLOTS(SLOTS), .SLOT_W(SLOT_W), .VC_W(VC_W), .TAG_W(TAG_W), .TIME_W(TIME_W)
    ) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_en   (arr_valid),
        .ins_vc   (arr_vc),
        .ins_tag  (arr_tag),
        .ins_due  (arr_due),
        .rel_en   (hs),
        .rel_slot (head_slot),
        .occ      (occ),
        .vc_q     (vc_q),
        .tag_q    (tag_q),
        .due_q    (due_q),
        .full     (pool_full),
        .overflow (overflow)
    );

    // Hides the departing cell from the search for its successor.
    always_comb begin
        rel_mask = '0;
        if (hs) rel_mask[head_slot] = 1'b1;
        cand_v = occ & ~rel_mask;
    end

    edf_min_tree #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .VC_W(VC_W), .TIME_W(TIME_W)) u_tree (
        .cand_v   (cand_v),
        .cand_vc  (vc_q),
        .cand_due (due_q),
        .win_v    (win_v),
        .win_slot (win_slot)
    );

    // Registers the offered cell; holds it while the link stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_v    <= 1'b0;
            head_slot <= '0;
            head_vc   <= '0;
            head_tag  <= '0;
            head_due  <= '0;
        end else if (!(head_v && !deq_ready)) begin
            head_v    <= win_v;
            head_slot <= win_slot;
            head_vc   <= vc_q[win_slot];
            head_tag  <= tag_q[win_slot];
            head_due  <= due_q[win_slot];
        end
    end

    assign deq_valid = head_v;
    assign deq_vc    = head_vc;
    assign deq_tag   = head_tag;
    assign deq_due   = head_due;

endmodule

// File: rtl/edf_sched_checker.sv
`timescale 1ns/1ps
// edf_sched_checker: temporal properties of the scheduler, bound to the top.
// Assumes it sees the top's ports plus pool occupancy and the offered slot number.
module edf_sched_checker #(
    parameter int SLOTS  = 8,
    parameter int SLOT_W = 3,
    parameter int VC_W   = 3,
    parameter int TAG_W  = 16,
    parameter int TIME_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arr_valid,
    input logic              deq_ready,
    input logic              deq_valid,
    input logic [VC_W-1:0]   deq_vc,
    input logic [TAG_W-1:0]  deq_tag,
    input logic [TIME_W-1:0] deq_due,
    input logic              overflow,
    input logic              pool_full,
    input logic [SLOTS-1:0]  occ,
    input logic [SLOT_W-1:0] head_slot
);

    // R1: a reset cycle leaves nothing offered and no drop recorded.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!deq_valid && !overflow));

    // R6: a stalled offer keeps every field.
    a_r6_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && !deq_ready) |=>
            (deq_valid && $stable(deq_vc) && $stable(deq_tag) && $stable(deq_due)));

    // R3: an arrival into a full pool raises the flag.
    a_r3_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && pool_full) |=> overflow);

    // R3: the flag never falls outside reset.
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R9: the accepted slot is not offered again on the next cycle.
    a_r9_slot_freed: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && deq_ready) |=> !(deq_valid && (head_slot == $past(head_slot))));

    // R10: the offered cell is still held in storage.
    a_r10_offer_stored: assert property (@(posedge clk) disable iff (!rst_n)
        deq_valid |-> occ[head_slot]);

endmodule

bind edf_cell_sched edf_sched_checker #(
    .SLOTS(SLOTS), .SLOT_W(SLOT_W), .VC_W(VC_W), .TAG_W(TAG_W), .TIME_W(TIME_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arr_valid (arr_valid),
    .deq_ready (deq_ready),
    .deq_valid (deq_valid),
    .deq_vc    (deq_vc),
    .deq_tag   (deq_tag),
    .deq_due   (deq_due),
    .overflow  (overflow),
    .pool_full (pool_full),
    .occ       (occ),
    .head_slot (head_slot)
);

// File: tb/tb_edf_cell_sched.sv
`timescale 1ns/1ps
module tb_edf_cell_sched;

    localparam int NV = 8, NS = 8, TW = 16, MW = 12, DW = 10, VW = 3;
    localparam int MOD = 1 << MW;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          arr_valid = 1'b0;
    logic [VW-1:0] arr_vc = '0;
    logic [TW-1:0] arr_tag = '0;
    logic          cfg_we = 1'b0;
    logic [VW-1:0] cfg_vc = '0;
    logic [DW-1:0] cfg_deadline = '0;
    logic          deq_ready = 1'b0;
    logic          deq_valid;
    logic [VW-1:0] deq_vc;
    logic [TW-1:0] deq_tag;
    logic [MW-1:0] deq_due;
    logic          overflow;

    edf_cell_sched #(.NUM_VC(NV), .SLOTS(NS), .TAG_W(TW), .TIME_W(MW), .DL_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_vc(arr_vc), .arr_tag(arr_tag),
        .cfg_we(cfg_we), .cfg_vc(cfg_vc), .cfg_deadline(cfg_deadline), .deq_ready(deq_ready),
        .deq_valid(deq_valid), .deq_vc(deq_vc), .deq_tag(deq_tag), .deq_due(deq_due),
        .overflow(overflow)
    );

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    bit cmp_on = 1'b0;

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, got, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    typedef struct { int id; int vc; int tag; int due; } cell_t;
    cell_t pool[$];
    int    dl_m[NV];
    int    now_m = 0;
    bit    mh_v = 0;
    cell_t mh;
    bit    m_ovf = 0;
    int    next_id = 0;

    function automatic bit earlier(cell_t a, cell_t b);
        int d;
        d = (a.due - b.due) & (MOD - 1);
        if (d == 0) return a.vc < b.vc;
        return d >= MOD / 2;
    endfunction

    always @(posedge clk) begin : model
        cell_t nc;
        cell_t best;
        bit    found;
        bit    add;
        bit    hs;
        int    old_id;
        if (!rst_n) begin
            pool.delete();
            now_m = 0; mh_v = 0; m_ovf = 0;
            foreach (dl_m[i]) dl_m[i] = 0;
        end else begin
            hs = mh_v && deq_ready;
            old_id = mh.id;
            add = 0;
            if (arr_valid) begin
                if (pool.size() == NS) m_ovf = 1;
                else begin
                    nc.id = next_id; next_id++;
                    nc.vc = int'(arr_vc); nc.tag = int'(arr_tag);
                    nc.due = (now_m + dl_m[arr_vc]) % MOD;
                    add = 1;
                end
            end
            if (!(mh_v && !deq_ready)) begin
                found = 0;
                foreach (pool[i]) begin
                    if (!(hs && pool[i].id == old_id)) begin
                        if (!found || earlier(pool[i], best)) begin
                            best = pool[i]; found = 1;
                        end
                    end
                end
                mh_v = found;
                if (found) mh = best;
            end
            if (hs) begin
                for (int i = 0; i < pool.size(); i++)
                    if (pool[i].id == old_id) begin pool.delete(i); break; end
            end
            if (add) pool.push_back(nc);
            if (cfg_we) dl_m[cfg_vc] = int'(cfg_deadline);
            now_m = (now_m + 1) % MOD;
        end
    end

    // Compare the design with the reference away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk(cur_req, "deq_valid", int'(deq_valid), int'(mh_v));
            if (mh_v && deq_valid) begin
                chk(cur_req, "deq_vc", int'(deq_vc), mh.vc);
                chk(cur_req, "deq_tag", int'(deq_tag), mh.tag);
                chk(cur_req, "deq_due", int'(deq_due), mh.due);
            end
            chk(cur_req, "overflow", int'(overflow), int'(m_ovf));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic arrive(input int vc, input int tag);
        arr_valid = 1'b1; arr_vc = VW'(vc); arr_tag = TW'(tag);
        @(negedge clk);
        arr_valid = 1'b0;
    endtask

    task automatic set_dl(input int vc, input int d);
        cfg_we = 1'b1; cfg_vc = VW'(vc); cfg_deadline = DW'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic take(input int exp_vc, input string req);
        int guard = 0;
        while (!deq_valid && guard < 50) begin @(negedge clk); guard++; end
        chk(req, "dequeue order vc", deq_valid ? int'(deq_vc) : -1, exp_vc);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmp_on = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "deq_valid in reset", int'(deq_valid), 0);
        chk("R1", "overflow in reset", int'(overflow), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "deq_valid after reset", int'(deq_valid), 0);
        cmp_on = 1'b1;
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin : main
        int t0;
        int n;
        @(negedge clk);
        do_reset();

        // R2: deadlines 30 + 5*vc; stamp and latency
        cur_req = "R2";
        for (int v = 0; v < NV; v++) set_dl(v, 30 + 5 * v);
        t0 = now_m;
        arr_valid = 1'b1; arr_vc = 3; arr_tag = 16'h1234;
        @(negedge clk);
        arr_valid = 1'b0;
        chk("R9", "not yet offered after first edge", int'(deq_valid), 0);
        @(negedge clk);
        chk("R9", "offered after second edge", int'(deq_valid), 1);
        chk("R2", "due = clock + deadline", int'(deq_due), (t0 + 45) % MOD);
        chk("R10", "tag carried", int'(deq_tag), 16'h1234);
        deq_ready = 1'b1;
        take(3, "R10");
        deq_ready = 1'b0;
        repeat (2) @(negedge clk);

        // R4 / R6: head held while more urgent cells arrive
        cur_req = "R6";
        arrive(7, 1);
        arrive(0, 2);
        arrive(4, 3);
        arrive(1, 4);
        repeat (3) @(negedge clk);
        chk("R6", "held head while stalled", int'(deq_vc), 7);
        cur_req = "R4";
        deq_ready = 1'b1;
        take(7, "R6");
        take(0, "R4");
        take(1, "R4");
        take(4, "R4");
        deq_ready = 1'b0;
        repeat (2) @(negedge clk);

        // R5: equal due times from VC5 and VC2
        cur_req = "R5";
        arrive(6, 10);
        arrive(5, 11);            // due = t + 55
        repeat (14) @(negedge clk);
        arrive(2, 12);            // due = t + 15 + 40 = t + 55
        repeat (2) @(negedge clk);
        deq_ready = 1'b1;
        take(6, "R5");
        take(2, "R5");
        take(5, "R5");
        deq_ready = 1'b0;
        repeat (2) @(negedge clk);

        // R8: deadline write in the same cycle as an arrival
        cur_req = "R8";
        t0 = now_m;
        cfg_we = 1'b1; cfg_vc = 3; cfg_deadline = 100;
        arr_valid = 1'b1; arr_vc = 3; arr_tag = 16'h0808;
        @(negedge clk);
        cfg_we = 1'b0; arr_tag = 16'h0809;
        @(negedge clk);
        arr_valid = 1'b0;
        @(negedge clk);
        chk("R8", "old deadline used by same-cycle arrival", int'(deq_due), (t0 + 45) % MOD);
        deq_ready = 1'b1;
        @(negedge clk);
        chk("R8", "new deadline used by later arrival", int'(deq_due), (t0 + 1 + 100) % MOD);
        @(negedge clk);
        deq_ready = 1'b0;
        repeat (2) @(negedge clk);

        // R7: ordering across clock rollover
        cur_req = "R7";
        set_dl(1, 5);
        while (now_m != MOD - 17) @(negedge clk);
        arrive(7, 20);
        arrive(0, 21);            // due wraps to 14
        arrive(1, 22);            // due 4086
        repeat (2) @(negedge clk);
        deq_ready = 1'b1;
        take(7, "R7");
        take(1, "R7");
        take(0, "R7");
        deq_ready = 1'b0;
        repeat (2) @(negedge clk);

        // R3 / R9: fill all slots, drop one, drop at the handshake edge
        cur_req = "R3";
        for (int i = 0; i < NS; i++) arrive(i, 16'h100 + i);
        chk("R3", "no drop while slots remain", int'(overflow), 0);
        arrive(5, 16'h1FF);
        chk("R3", "drop flagged", int'(overflow), 1);
        cur_req = "R9";
        deq_ready = 1'b1;
        arr_valid = 1'b1; arr_vc = 0; arr_tag = 16'h2FF;
        @(negedge clk);
        arr_valid = 1'b0;
        n = 0;
        repeat (20) begin
            if (deq_valid) n++;
            @(negedge clk);
        end
        chk("R9", "freed slot not reused at same edge", n, NS - 1);
        chk("R3", "flag sticky", int'(overflow), 1);
        deq_ready = 1'b0;

        do_reset();

        // R4: mixed traffic against the reference
        cur_req = "R4";
        for (int v = 0; v < NV; v++) set_dl(v, 8 + 9 * ((v * 5) % NV));
        for (int c = 0; c < 3000; c++) begin
            arr_valid = ($urandom % 2) == 0;
            arr_vc = VW'($urandom % NV);
            arr_tag = TW'(c);
            deq_ready = ($urandom % 5) < 3;
            @(negedge clk);
        end
        arr_valid = 1'b0;
        deq_ready = 1'b1;
        repeat (20) @(negedge clk);
        chk("R4", "drained", int'(deq_valid), 0);

        report();
        $finish;
    end

endmodule